// File: doc/BRIEF.md
# Interlaced Video Timing Generator with VBI Gating

This block is the timing master for an interlaced digital video path, 525-line/60 Hz or 625-line/50 Hz. It advances one byte position on each cycle where the byte enable is high. From the byte and line counts it derives the horizontal-blank (H), vertical-blank (V) and field (F) flags and drives each one on its own output. It builds the 8-bit byte stream, which carries the four-byte end-of-active and start-of-active timing codes at fixed places in every line.

Blanking samples fill the ancillary interval of each line and every active sample that is blanked. On lines outside vertical blanking the incoming YCbCr byte passes through unchanged. A mode input selects what happens inside vertical blanking. With partial blanking, incoming data is forwarded on the lines that carry no sync or equalization pulses, so teletext-style or copy-control data can ride through, and a per-sample enable marks those samples. With full blanking, the whole vertical interval is blanked.

The standard-select input is sampled only at the top of a frame. A change in mid-frame therefore never produces a broken frame.

Top module: `vid_timing_gen`

## Requirements
- R1: All outputs update only on a clock edge where `ce` is high. On any other edge every output keeps its value.
- R2: While `rst_n` is low, `dout`, `h_flag`, `v_flag`, `f_flag` and `vbi_pass` are all 0. After reset the first position is byte 0 of line 1, and the first frame uses the 525-line standard unless `std_sel` (0 = 525, 1 = 625) is 1 at that first enable.
- R3: A line of length L has four timing-code bytes at positions 0..3 and four more at positions 4+A..7+A, where A is the ancillary length (268 for 525 lines, 280 for 625 lines). Each code is FF, 00, 00, XY. XY bit 7 is 1, bits 6..4 are F, V, H, and bits 3..0 are V^H, F^H, F^V, F^V^H.
- R4: H is 1 from byte 0 up to the last byte before the second code, and 0 from the second code to the end of the line.
- R5: For 525 lines, V is 1 on lines 1..21, 262..284 and 525. For 625 lines, V is 1 on lines 1..22, 311..335, 624 and 625.
- R6: For 525 lines, F is 1 on lines 266..525 and 1..3. For 625 lines, F is 1 on lines 313..625. F is 0 on all other lines.
- R7: A line holds 8+A+1440 byte positions (1716 or 1728). Lines count 1..525 or 1..625 and then wrap to 1.
- R8: Ancillary bytes and blanked active bytes alternate 0x80 and 0x10. The value is 0x80 at an even offset from the first byte of the interval and 0x10 at an odd offset.
- R9: On active bytes of lines where V is 0, `dout` equals the `din` presented with that enable.
- R10: With `partial_blank`=1, `vbi_pass` is 1 and `din` is forwarded on the active bytes of these lines: 525 lines 10..21 and 274..284, plus line 273 from active offset 720 onward; 625 lines 7..22 and 319..335. All other active bytes with V=1 are blanked.
- R11: With `partial_blank`=0, `vbi_pass` stays 0 and every active byte with V=1 is blanked.
- R12: A new `std_sel` value takes effect only at byte 0 of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Byte enable, one per byte period |
| std_sel | input | 1 | Standard request: 0 = 525/60, 1 = 625/50 |
| partial_blank | input | 1 | 1 = forward data on the open VBI lines, 0 = blank the whole VBI |
| din | input | 8 | Incoming multiplexed YCbCr byte |
| dout | output | 8 | Outgoing byte stream with timing codes |
| h_flag | output | 1 | Horizontal blanking flag |
| v_flag | output | 1 | Vertical blanking flag |
| f_flag | output | 1 | Field flag |
| vbi_pass | output | 1 | Marks an active byte forwarded inside VBI |

## Verification
The assertions assume that `ce` is the only thing that moves the counters. They also assume that `partial_blank` and `din` are sampled in the same enable cycle as the byte they affect, so a value that changes between enables has no effect. The stimulus changes inputs only on falling clock edges and holds them across the following rising edge. It toggles `std_sel` in the middle of frames, inserts idle gaps in `ce` for one whole frame, and runs full frames of both standards in both blanking modes. The geometry parameters are shrunk so that complete frames fit into the run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} vstd_e;

  typedef enum logic [1:0] {RG_EAV, RG_ANC, RG_SAV, RG_ACT} region_e;

  typedef struct packed {
    logic h;
    logic v;
    logic f;
  } flags_t;

  function automatic int frame_lines(vstd_e s);
    return (s == STD_625) ? 625 : 525;
  endfunction

  // vertical blanking membership per standard
  function automatic logic in_vbi(vstd_e s, int ln);
    if (s == STD_625)
      return (ln >= 624) || (ln <= 22) || (ln >= 311 && ln <= 335);
    return (ln == 525) || (ln <= 21) || (ln >= 262 && ln <= 284);
  endfunction

  // lines free of sync/equalization pulses; late_half marks second half of active
  function automatic logic in_open(vstd_e s, int ln, logic late_half);
    if (s == STD_625)
      return (ln >= 7 && ln <= 22) || (ln >= 319 && ln <= 335);
    return (ln >= 10 && ln <= 21) || (ln >= 274 && ln <= 284) ||
           (ln == 273 && late_half);
  endfunction

  function automatic logic field_bit(vstd_e s, int ln);
    if (s == STD_625)
      return ln >= 313;
    return (ln >= 266) || (ln <= 3);
  endfunction

  function automatic logic [7:0] xy_word(flags_t fl);
    return {1'b1, fl.f, fl.v, fl.h,
            fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
  endfunction

  function automatic logic [7:0] code_byte(logic [1:0] idx, flags_t fl);
    case (idx)
      2'd0:    return 8'hFF;
      2'd3:    return xy_word(fl);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int LINE_W  = 10,
  parameter int LEN_525 = 1716,
  parameter int LEN_625 = 1728
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              std_sel,
  output logic [POS_W-1:0]  pos,
  output logic [LINE_W-1:0] line,
  output vstd_e             std_eff,
  output logic              frame_top,
  output logic              line_start
);

  localparam logic [POS_W-1:0]  LAST_525 = POS_W'(LEN_525 - 1);
  localparam logic [POS_W-1:0]  LAST_625 = POS_W'(LEN_625 - 1);
  localparam logic [LINE_W-1:0] TOP_LINE = LINE_W'(1);

  logic [POS_W-1:0]  pos_q;
  logic [LINE_W-1:0] line_q;
  vstd_e             std_q;
  logic              last_pos, last_line;

  assign frame_top  = (pos_q == '0) && (line_q == TOP_LINE);
  assign line_start = ce && (pos_q == '0);
  assign std_eff    = frame_top ? vstd_e'(std_sel) : std_q;
  assign last_pos   = pos_q == ((std_eff == STD_625) ? LAST_625 : LAST_525);
  assign last_line  = line_q == LINE_W'(frame_lines(std_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      line_q <= TOP_LINE;
      std_q  <= STD_525;
    end else if (ce) begin
      std_q <= std_eff;
      if (last_pos) begin
        pos_q  <= '0;
        line_q <= last_line ? TOP_LINE : line_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos  = pos_q;
  assign line = line_q;

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int LINE_W  = 10,
  parameter int ACT_LEN = 1440,
  parameter int ANC_525 = 268,
  parameter int ANC_625 = 280
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [LINE_W-1:0] line,
  input  vstd_e             std,
  output flags_t            flags,
  output region_e           region,
  output logic [1:0]        code_idx,
  output logic              blank_odd,
  output logic              open_slot
);

  localparam logic [POS_W-1:0] SAV_525 = POS_W'(4 + ANC_525);
  localparam logic [POS_W-1:0] SAV_625 = POS_W'(4 + ANC_625);
  localparam logic [POS_W-1:0] ACT_525 = POS_W'(8 + ANC_525);
  localparam logic [POS_W-1:0] ACT_625 = POS_W'(8 + ANC_625);
  localparam logic [POS_W-1:0] HALF    = POS_W'(ACT_LEN / 2);
  localparam logic [POS_W-1:0] CODE_N  = POS_W'(4);

  logic [POS_W-1:0] sav_at, act_at, sav_off, act_off;
  logic             late_half;

  always_comb begin
    sav_at  = (std == STD_625) ? SAV_625 : SAV_525;
    act_at  = (std == STD_625) ? ACT_625 : ACT_525;
    sav_off = pos - sav_at;
    act_off = pos - act_at;

    if (pos < CODE_N)      region = RG_EAV;
    else if (pos < sav_at) region = RG_ANC;
    else if (pos < act_at) region = RG_SAV;
    else                   region = RG_ACT;

    code_idx  = (region == RG_SAV) ? sav_off[1:0] : pos[1:0];
    // ancillary starts at an even position, so pos parity is its offset parity
    blank_odd = (region == RG_ANC) ? pos[0] : act_off[0];
    late_half = act_off >= HALF;

    flags.h = pos < sav_at;
    flags.v = in_vbi(std, int'(line));
    flags.f = field_bit(std, int'(line));

    open_slot = (region == RG_ACT) && flags.v &&
                in_open(std, int'(line), late_half);
  end

endmodule

// File: rtl/vtg_stream.sv
module vtg_stream
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  region_e    region,
  input  logic [1:0] code_idx,
  input  logic       blank_odd,
  input  flags_t     flags,
  input  logic       open_slot,
  input  logic       partial_blank,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       h_out,
  output logic       v_out,
  output logic       f_out,
  output logic       pass_out
);

  logic       pass_nxt;
  logic [7:0] blank_byte, byte_nxt;

  always_comb begin
    pass_nxt   = partial_blank && open_slot;
    blank_byte = blank_odd ? 8'h10 : 8'h80;
    case (region)
      RG_EAV, RG_SAV: byte_nxt = code_byte(code_idx, flags);
      RG_ANC:         byte_nxt = blank_byte;
      default:        byte_nxt = (!flags.v || pass_nxt) ? din : blank_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      h_out    <= 1'b0;
      v_out    <= 1'b0;
      f_out    <= 1'b0;
      pass_out <= 1'b0;
    end else if (ce) begin
      dout     <= byte_nxt;
      h_out    <= flags.h;
      v_out    <= flags.v;
      f_out    <= flags.f;
      pass_out <= pass_nxt;
    end
  end

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int ACT_LEN = 1440,
  parameter int ANC_525 = 268,
  parameter int ANC_625 = 280
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       std_sel,
  input  logic       partial_blank,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       h_flag,
  output logic       v_flag,
  output logic       f_flag,
  output logic       vbi_pass
);

  localparam int LEN_525 = 8 + ANC_525 + ACT_LEN;
  localparam int LEN_625 = 8 + ANC_625 + ACT_LEN;
  localparam int LEN_MAX = (LEN_625 > LEN_525) ? LEN_625 : LEN_525;
  localparam int POS_W   = $clog2(LEN_MAX);
  localparam int LINE_W  = $clog2(626);

  // named internal events, observed by the bound checker
  logic [POS_W-1:0]  pos;
  logic [LINE_W-1:0] line;
  vstd_e             std_eff;
  logic              frame_top, line_start;
  flags_t            flags;
  region_e           region;
  logic [1:0]        code_idx;
  logic              blank_odd, open_slot;

  vtg_counter #(
    .POS_W(POS_W), .LINE_W(LINE_W), .LEN_525(LEN_525), .LEN_625(LEN_625)
  ) i_counter (
    .clk(clk), .rst_n(rst_n), .ce(ce), .std_sel(std_sel),
    .pos(pos), .line(line), .std_eff(std_eff),
    .frame_top(frame_top), .line_start(line_start)
  );

  vtg_decode #(
    .POS_W(POS_W), .LINE_W(LINE_W), .ACT_LEN(ACT_LEN),
    .ANC_525(ANC_525), .ANC_625(ANC_625)
  ) i_decode (
    .pos(pos), .line(line), .std(std_eff), .flags(flags), .region(region),
    .code_idx(code_idx), .blank_odd(blank_odd), .open_slot(open_slot)
  );

  vtg_stream i_stream (
    .clk(clk), .rst_n(rst_n), .ce(ce), .region(region),
    .code_idx(code_idx), .blank_odd(blank_odd), .flags(flags),
    .open_slot(open_slot), .partial_blank(partial_blank), .din(din),
    .dout(dout), .h_out(h_flag), .v_out(v_flag), .f_out(f_flag),
    .pass_out(vbi_pass)
  );

endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk
  import vtg_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int LINE_W  = 10,
  parameter int LEN_MAX = 1728
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              partial_blank,
  input logic [7:0]        dout,
  input logic              h_flag,
  input logic              v_flag,
  input logic              f_flag,
  input logic              vbi_pass,
  input logic [POS_W-1:0]  pos,
  input logic [LINE_W-1:0] line,
  input vstd_e             std_eff,
  input logic              frame_top,
  input logic              line_start
);

  localparam logic [POS_W-1:0]  POS_LIM  = POS_W'(LEN_MAX);
  localparam logic [LINE_W-1:0] LINE_LIM = LINE_W'(625);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(dout) && $stable(h_flag) && $stable(v_flag) &&
             $stable(f_flag) && $stable(vbi_pass)));

  assert_eav_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pos == '0) |=> (dout == 8'hFF && h_flag));

  assert_f_line_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(f_flag) |-> $past(line_start));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line != '0) && (line <= LINE_LIM) && (pos < POS_LIM));

  assert_pass_scope_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_pass |-> (v_flag && !h_flag));

  assert_full_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !partial_blank) |=> !vbi_pass);

  assert_std_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !frame_top) |=> (frame_top || std_eff == $past(std_eff)));

endmodule

bind vid_timing_gen vid_timing_gen_chk #(
  .POS_W(POS_W), .LINE_W(LINE_W), .LEN_MAX(LEN_MAX)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .partial_blank(partial_blank),
  .dout(dout), .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag),
  .vbi_pass(vbi_pass), .pos(pos), .line(line), .std_eff(std_eff),
  .frame_top(frame_top), .line_start(line_start)
);

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;

  localparam int ACT = 16;
  localparam int A5  = 8;
  localparam int A6  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic       std_sel = 1'b0;
  logic       partial_blank = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       h_flag, v_flag, f_flag, vbi_pass;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vid_timing_gen #(.ACT_LEN(ACT), .ANC_525(A5), .ANC_625(A6)) i_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .ce(ce), .std_sel(std_sel),
    .partial_blank(partial_blank), .din(din), .dout(dout),
    .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag), .vbi_pass(vbi_pass)
  );

  typedef struct {
    logic [7:0] d;
    logic       h, v, f, p;
    string      dtag, ptag;
  } exp_t;

  exp_t q[$];

  // independent reference state
  int m_pos = 0;
  int m_line = 1;
  int m_625 = 0;

  function automatic bit ref_vbi(int s, int ln);
    if (s == 1) begin
      case (ln) inside
        [1:22], [311:335], [624:625]: return 1;
        default: return 0;
      endcase
    end
    case (ln) inside
      [1:21], [262:284], 525: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_open(int s, int ln, int off);
    if (s == 1) begin
      case (ln) inside
        [7:22], [319:335]: return 1;
        default: return 0;
      endcase
    end
    if (ln == 273) return off >= ACT / 2;
    case (ln) inside
      [10:21], [274:284]: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_field(int s, int ln);
    if (s == 1) return ln > 312;
    return !(ln > 3 && ln < 266);
  endfunction

  function automatic logic [7:0] ref_code(int k, bit f, bit v, bit h);
    if (k == 0) return 8'hFF;
    if (k != 3) return 8'h00;
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic push_expect(input logic [7:0] data);
    exp_t e;
    int   anc, len, sav, act, off;
    if (m_pos == 0 && m_line == 1) m_625 = int'(std_sel);  // R12
    anc = m_625 ? A6 : A5;
    sav = 4 + anc;
    act = sav + 4;
    len = act + ACT;
    e.h = m_pos < sav;
    e.v = ref_vbi(m_625, m_line);
    e.f = ref_field(m_625, m_line);
    e.p = 1'b0;
    e.ptag = partial_blank ? "R10" : "R11";
    if (m_pos < 4) begin
      e.d = ref_code(m_pos, e.f, e.v, e.h); e.dtag = "R3";
    end else if (m_pos < sav) begin
      e.d = ((m_pos - 4) % 2 == 0) ? 8'h80 : 8'h10; e.dtag = "R8";
    end else if (m_pos < act) begin
      e.d = ref_code(m_pos - sav, e.f, e.v, e.h); e.dtag = "R3";
    end else begin
      off = m_pos - act;
      e.p = partial_blank && e.v && ref_open(m_625, m_line, off);
      if (!e.v) begin
        e.d = data; e.dtag = "R9";
      end else if (e.p) begin
        e.d = data; e.dtag = "R10";
      end else begin
        e.d = (off % 2 == 0) ? 8'h80 : 8'h10;
        e.dtag = partial_blank ? "R8 R10" : "R8 R11";
      end
    end
    q.push_back(e);
    // R7 line length and wrap
    if (m_pos == len - 1) begin
      m_pos = 0;
      m_line = (m_line == (m_625 ? 625 : 525)) ? 1 : m_line + 1;
    end else begin
      m_pos++;
    end
  endtask

  task automatic step(input logic en, input logic [7:0] data);
    @(negedge clk);
    ce  = en;
    din = data;
    if (en) push_expect(data);
  endtask

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (line %0d)", tag, act_v, exp_v, m_line);
    end
  endtask

  // monitor
  logic       took = 1'b0;
  bit         live = 0;
  logic [7:0] p_d;
  logic       p_h, p_v, p_f, p_p;

  always @(posedge clk) took = ce;

  always @(negedge clk) begin
    if (live) begin
      if (took) begin
        if (q.size() == 0) begin
          chk(0, "R7 scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(dout == e.d, e.dtag, dout, e.d);
          chk(h_flag == e.h, "R4 R7", h_flag, e.h);
          chk(v_flag == e.v, "R5 R7", v_flag, e.v);
          chk(f_flag == e.f, "R6 R12", f_flag, e.f);
          chk(vbi_pass == e.p, e.ptag, vbi_pass, e.p);
        end
      end else begin
        chk(dout == p_d && h_flag == p_h && v_flag == p_v && f_flag == p_f &&
            vbi_pass == p_p, "R1 hold",
            {dout, h_flag, v_flag, f_flag, vbi_pass},
            {p_d, p_h, p_v, p_f, p_p});
      end
    end
    p_d = dout; p_h = h_flag; p_v = v_flag; p_f = f_flag; p_p = vbi_pass;
  end

  task automatic run_frame(input int lines, input int len, input int gap,
                           input int flip_at, input logic flip_val);
    int done = 0;
    int cyc = 0;
    while (done < lines * len) begin
      if (done == flip_at) std_sel = flip_val;
      if (gap != 0 && (cyc % gap) == gap - 1) begin
        step(1'b0, 8'hEE);
      end else begin
        step(1'b1, 8'((done * 37 + 11) ^ (done >> 3)));
        done++;
      end
      cyc++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    partial_blank = 1'b1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(dout == 8'h00 && !h_flag && !v_flag && !f_flag && !vbi_pass, "R2 reset",
        {dout, h_flag, v_flag, f_flag, vbi_pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    p_d = dout; p_h = h_flag; p_v = v_flag; p_f = f_flag; p_p = vbi_pass;
    live = 1;
    // 525 partial blanking; request 625 mid-frame (R12 defers it)
    run_frame(525, 8 + A5 + ACT, 0, 100 * (8 + A5 + ACT), 1'b1);
    // 625 partial blanking with enable gaps (R1)
    run_frame(625, 8 + A6 + ACT, 5, -1, 1'b1);
    // 625 full blanking, request 525 mid-frame
    partial_blank = 1'b0;
    run_frame(625, 8 + A6 + ACT, 0, 300 * (8 + A6 + ACT), 1'b0);
    // 525 full blanking
    run_frame(525, 8 + A5 + ACT, 0, -1, 1'b0);
    repeat (4) step(1'b0, 8'h00);
    chk(q.size() == 0, "R7 drain", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule